// File: doc/BRIEF.md
# Fixed-Width Instruction Decoder

This block takes one 32-bit instruction word and splits it, in the same cycle, into everything the rest of a small load/store core needs to execute it. It reports the 6-bit opcode and the 3-bit operation group carried in the opcode's top bits. It also reports the three 5-bit register indices and the low 16 bits of the word, sign-extended to the data width. Alongside the fields it drives a set of control strobes:

- register write enable, and the index of the register to write;
- memory read and memory write;
- stack push and stack pop;
- conditional branch, jump, call and return;
- system call;
- a flag for an undefined opcode.

The decoder has no state. Its outputs follow the instruction input with only gate delay, so it can sit between an instruction register and the execute stage without adding a cycle. The register file, the arithmetic unit, memory and trap handling are outside it. An undefined opcode only raises the illegal flag and holds every other strobe low, so downstream logic can take the trap without first undoing side effects.

Top module: `rdec_top`

## Requirements
- R1: Register index a is instruction bits 25:21, index b is bits 20:16 and index c is bits 15:11. All three are output for every instruction word.
- R2: The immediate output is instruction bits 15:0 sign-extended to 32 bits, so a word whose bit 15 is 1 yields upper bits of all ones.
- R3: The opcode output is instruction bits 31:26, and the group output is bits 31:29.
- R4: The defined opcodes, in octal, are 00 add, 01 subtract, 02 multiply, 03 divide, 04 remainder, 10 and, 11 or, 20 compare, 21 equal, 22 not-equal, 23 less, 24 less-or-equal, 25 greater-or-equal, 26 greater, 30 move-immediate, 31 load, 32 store, 33 push, 34 pop, 40 branch-if-zero, 41 jump, 42 call, 43 return and 70 system call. The illegal flag is 1 for every other opcode value and 0 for these.
- R5: Register write enable is 1 for opcodes 00–04, 10, 11, 21–26, 30, 31 and 34. It is 0 for compare, store, push, the four control-flow opcodes, system call and any undefined opcode.
- R6: The write index is field b for load (31) and field a for every other writing opcode. It is 0 whenever write enable is 0.
- R7: Memory read is 1 exactly for load, pop and return (31, 34, 43). Memory write is 1 exactly for store, push and call (32, 33, 42).
- R8: Stack push is 1 exactly for push and call (33, 42). Stack pop is 1 exactly for pop and return (34, 43).
- R9: Each control-flow opcode has its own strobe: conditional branch for 40, jump for 41, call for 42 and return for 43.
- R10: The system-call strobe is 1 exactly for opcode 70.
- R11: When the illegal flag is 1, every other strobe is 0.
- R12: At most one of the four control-flow strobes is 1 for any instruction word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word to decode |
| opcode | output | 6 | Opcode field |
| group | output | 3 | Operation group (top opcode bits) |
| ra_idx | output | 5 | Register field a |
| rb_idx | output | 5 | Register field b |
| rc_idx | output | 5 | Register field c |
| imm | output | 32 | Sign-extended immediate |
| reg_we | output | 1 | Register file write enable |
| wr_idx | output | 5 | Register index to write |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| stk_push | output | 1 | Stack pointer pre-decrement and store |
| stk_pop | output | 1 | Load and stack pointer post-increment |
| br_cond | output | 1 | Branch if register a is zero |
| jmp | output | 1 | Unconditional relative jump |
| call | output | 1 | Relative call |
| ret | output | 1 | Return from call |
| sys | output | 1 | System call |
| illegal | output | 1 | Undefined opcode |

## Verification
The block has no stored state, so a fault can only be a wrong mapping from instruction bits to outputs. It shows up in the same evaluation as the instruction that exposes it. A misplaced field boundary or a wrong sign-extension bit appears as a wrong index or immediate on any word with distinct bit patterns. A wrong entry in the opcode table appears as one strobe that is set or cleared for one opcode, which is why every one of the 64 opcode values is applied with several field patterns. The cross-strobe rules (stack operations imply memory access, undefined opcodes are silent, at most one control-flow strobe) are checked on every word.

// File: rtl/rdec_pkg.sv
// Shared opcode encodings, group codes and the control bundle used by the
// instruction decoder. Assumes a 6-bit opcode whose top 3 bits give the group.
package rdec_pkg;

    localparam int OPC_W = 6;
    localparam int GRP_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 6'o00, OP_SUB  = 6'o01, OP_MUL  = 6'o02,
        OP_DIV  = 6'o03, OP_REM  = 6'o04,
        OP_AND  = 6'o10, OP_OR   = 6'o11,
        OP_CMP  = 6'o20, OP_SEQ  = 6'o21, OP_SNE  = 6'o22,
        OP_SLT  = 6'o23, OP_SLE  = 6'o24, OP_SGE  = 6'o25,
        OP_SGT  = 6'o26,
        OP_MOVI = 6'o30, OP_LOAD = 6'o31, OP_STOR = 6'o32,
        OP_PUSH = 6'o33, OP_POP  = 6'o34,
        OP_BRZ  = 6'o40, OP_JUMP = 6'o41, OP_CALL = 6'o42,
        OP_RETN = 6'o43,
        OP_TRAP = 6'o70
    } rdec_op_e;

    typedef enum logic [GRP_W-1:0] {
        GRP_ARITH = 3'o0,
        GRP_LOGIC = 3'o1,
        GRP_COND  = 3'o2,
        GRP_DATA  = 3'o3,
        GRP_FLOW  = 3'o4,
        GRP_MISC  = 3'o7
    } rdec_grp_e;

    typedef struct packed {
        logic reg_we;
        logic wsel_b;
        logic mem_rd;
        logic mem_wr;
        logic stk_push;
        logic stk_pop;
        logic br_cond;
        logic jmp;
        logic call;
        logic ret;
        logic sys;
    } rdec_ctrl_t;

endpackage

// File: rtl/rdec_field_split.sv
// Field extraction: pulls the three register indices and the sign-extended
// immediate out of the instruction word. Assumes the register fields sit
// directly below the opcode, packed back to back, and the immediate is the
// low IMM_W bits.
module rdec_field_split #(
    parameter int INSN_W = 32,
    parameter int XLEN   = 32,
    parameter int REG_W  = 5,
    parameter int IMM_W  = 16
) (
    input  logic [INSN_W-1:0] insn,
    output logic [REG_W-1:0]  ra_idx,
    output logic [REG_W-1:0]  rb_idx,
    output logic [REG_W-1:0]  rc_idx,
    output logic [XLEN-1:0]   imm
);
    localparam int NFIELD = 3;
    localparam int TOP    = INSN_W - rdec_pkg::OPC_W;
    localparam int EXT_W  = XLEN - IMM_W;

    logic [NFIELD-1:0][REG_W-1:0] fld;

    // One slice per register field, counted down from just below the opcode.
    for (genvar i = 0; i < NFIELD; i++) begin : g_fld
        localparam int LSB = TOP - (i + 1) * REG_W;
        assign fld[i] = insn[LSB +: REG_W];
    end

    assign ra_idx = fld[0];
    assign rb_idx = fld[1];
    assign rc_idx = fld[2];

    // Replicate the immediate's top bit into the upper part of the word.
    always_comb begin
        imm = {{EXT_W{insn[IMM_W-1]}}, insn[IMM_W-1:0]};
    end

endmodule

// File: rtl/rdec_op_classify.sv
// Opcode classification: reports whether the opcode is one of the defined
// encodings. Assumes the opcode is given already extracted.
module rdec_op_classify (
    input  logic [rdec_pkg::OPC_W-1:0] opcode,
    output logic                       legal
);
    import rdec_pkg::*;

    // Match the opcode against the defined set.
    always_comb begin
        case (opcode)
            OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_REM,
            OP_AND, OP_OR,
            OP_CMP, OP_SEQ, OP_SNE, OP_SLT, OP_SLE, OP_SGE, OP_SGT,
            OP_MOVI, OP_LOAD, OP_STOR, OP_PUSH, OP_POP,
            OP_BRZ, OP_JUMP, OP_CALL, OP_RETN,
            OP_TRAP:  legal = 1'b1;
            default:  legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/rdec_ctrl_gen.sv
// Control generation: maps a defined opcode to its strobe bundle. Assumes
// the legal input comes from the classifier; an undefined opcode gives an
// all-zero bundle.
module rdec_ctrl_gen (
    input  logic [rdec_pkg::OPC_W-1:0] opcode,
    input  logic                       legal,
    output rdec_pkg::rdec_ctrl_t       ctrl
);
    import rdec_pkg::*;

    rdec_ctrl_t raw;

    // Per-opcode strobe table.
    always_comb begin
        raw = '0;
        case (opcode)
            OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_REM,
            OP_AND, OP_OR,
            OP_SEQ, OP_SNE, OP_SLT, OP_SLE, OP_SGE, OP_SGT,
            OP_MOVI:  raw.reg_we = 1'b1;
            OP_LOAD: begin
                raw.reg_we = 1'b1;
                raw.wsel_b = 1'b1;
                raw.mem_rd = 1'b1;
            end
            OP_STOR:  raw.mem_wr = 1'b1;
            OP_PUSH: begin
                raw.mem_wr   = 1'b1;
                raw.stk_push = 1'b1;
            end
            OP_POP: begin
                raw.reg_we  = 1'b1;
                raw.mem_rd  = 1'b1;
                raw.stk_pop = 1'b1;
            end
            OP_BRZ:   raw.br_cond = 1'b1;
            OP_JUMP:  raw.jmp = 1'b1;
            OP_CALL: begin
                raw.call     = 1'b1;
                raw.mem_wr   = 1'b1;
                raw.stk_push = 1'b1;
            end
            OP_RETN: begin
                raw.ret     = 1'b1;
                raw.mem_rd  = 1'b1;
                raw.stk_pop = 1'b1;
            end
            OP_TRAP:  raw.sys = 1'b1;
            default:  raw = '0;
        endcase
    end

    // Silence every strobe for an undefined opcode.
    always_comb begin
        ctrl = legal ? raw : '0;
    end

endmodule

// File: rtl/rdec_top.sv
// Instruction decoder top: splits a fixed-width instruction into opcode,
// group, register indices and immediate, and drives the execute-stage
// strobes. Purely combinational; assumes the caller registers the word.
module rdec_top #(
    parameter int INSN_W = 32,
    parameter int XLEN   = 32,
    parameter int REG_W  = 5,
    parameter int IMM_W  = 16
) (
    input  logic [INSN_W-1:0]          insn,
    output logic [rdec_pkg::OPC_W-1:0] opcode,
    output logic [rdec_pkg::GRP_W-1:0] group,
    output logic [REG_W-1:0]           ra_idx,
    output logic [REG_W-1:0]           rb_idx,
    output logic [REG_W-1:0]           rc_idx,
    output logic [XLEN-1:0]            imm,
    output logic                       reg_we,
    output logic [REG_W-1:0]           wr_idx,
    output logic                       mem_rd,
    output logic                       mem_wr,
    output logic                       stk_push,
    output logic                       stk_pop,
    output logic                       br_cond,
    output logic                       jmp,
    output logic                       call,
    output logic                       ret,
    output logic                       sys,
    output logic                       illegal
);
    import rdec_pkg::*;

    localparam int OPC_LSB = INSN_W - OPC_W;

    logic       legal;
    rdec_ctrl_t ctrl;

    assign opcode = insn[INSN_W-1:OPC_LSB];
    assign group  = opcode[OPC_W-1 -: GRP_W];

    rdec_field_split #(
        .INSN_W (INSN_W),
        .XLEN   (XLEN),
        .REG_W  (REG_W),
        .IMM_W  (IMM_W)
    ) split_i (
        .insn   (insn),
        .ra_idx (ra_idx),
        .rb_idx (rb_idx),
        .rc_idx (rc_idx),
        .imm    (imm)
    );

    rdec_op_classify class_i (
        .opcode (opcode),
        .legal  (legal)
    );

    rdec_ctrl_gen ctrl_i (
        .opcode (opcode),
        .legal  (legal),
        .ctrl   (ctrl)
    );

    // Fan the control bundle out to the individual strobe ports.
    always_comb begin
        illegal  = ~legal;
        reg_we   = ctrl.reg_we;
        mem_rd   = ctrl.mem_rd;
        mem_wr   = ctrl.mem_wr;
        stk_push = ctrl.stk_push;
        stk_pop  = ctrl.stk_pop;
        br_cond  = ctrl.br_cond;
        jmp      = ctrl.jmp;
        call     = ctrl.call;
        ret      = ctrl.ret;
        sys      = ctrl.sys;
    end

    // Pick the destination field; zero when nothing is written.
    always_comb begin
        if (!ctrl.reg_we)     wr_idx = '0;
        else if (ctrl.wsel_b) wr_idx = rb_idx;
        else                  wr_idx = ra_idx;
    end

endmodule

// File: rtl/rdec_top_chk.sv
// Cross-output consistency checker for the decoder. The block holds no
// state, so the checks are immediate assertions re-evaluated whenever an
// output changes.
module rdec_top_chk #(
    parameter int XLEN  = 32,
    parameter int REG_W = 5,
    parameter int IMM_W = 16
) (
    input logic [rdec_pkg::OPC_W-1:0] opcode,
    input logic [rdec_pkg::GRP_W-1:0] group,
    input logic [XLEN-1:0]            imm,
    input logic                       reg_we,
    input logic [REG_W-1:0]           wr_idx,
    input logic                       mem_rd,
    input logic                       mem_wr,
    input logic                       stk_push,
    input logic                       stk_pop,
    input logic                       br_cond,
    input logic                       jmp,
    input logic                       call,
    input logic                       ret,
    input logic                       sys,
    input logic                       illegal
);
    localparam int EXT_W = XLEN - IMM_W + 1;

    // Check the strobe and field relations on every output change.
    always_comb begin
        p_illegal_quiet_r11: assert (!illegal || !(reg_we | mem_rd | mem_wr | stk_push |
                                     stk_pop | br_cond | jmp | call | ret | sys));
        p_flow_onehot_r12:   assert ($onehot0({br_cond, jmp, call, ret}));
        p_push_store_r8:     assert (!stk_push || mem_wr);
        p_pop_load_r8:       assert (!stk_pop || mem_rd);
        p_idle_index_r6:     assert (reg_we || wr_idx == '0);
        p_imm_ext_r2:        assert (imm[XLEN-1 -: EXT_W] == '0 || imm[XLEN-1 -: EXT_W] == '1);
        p_group_top_r3:      assert (group == opcode[rdec_pkg::OPC_W-1 -: rdec_pkg::GRP_W]);
        p_sys_only_r10:      assert (!sys || opcode == 6'o70);
    end

endmodule

bind rdec_top rdec_top_chk #(
    .XLEN  (XLEN),
    .REG_W (REG_W),
    .IMM_W (IMM_W)
) chk_i (
    .opcode   (opcode),
    .group    (group),
    .imm      (imm),
    .reg_we   (reg_we),
    .wr_idx   (wr_idx),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .stk_push (stk_push),
    .stk_pop  (stk_pop),
    .br_cond  (br_cond),
    .jmp      (jmp),
    .call     (call),
    .ret      (ret),
    .sys      (sys),
    .illegal  (illegal)
);

// File: tb/rdec_top_tb_top.sv
// Directed bench for the instruction decoder. Each scenario task drives
// words on the falling clock edge and checks the ports a quarter period
// later against a model built from the requirement list.
module rdec_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = '0;

    logic [5:0]  opcode;
    logic [2:0]  group;
    logic [4:0]  ra_idx, rb_idx, rc_idx, wr_idx;
    logic [31:0] imm;
    logic        reg_we, mem_rd, mem_wr, stk_push, stk_pop;
    logic        br_cond, jmp, call, ret, sys, illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rdec_top dut_i (
        .insn     (insn),
        .opcode   (opcode),
        .group    (group),
        .ra_idx   (ra_idx),
        .rb_idx   (rb_idx),
        .rc_idx   (rc_idx),
        .imm      (imm),
        .reg_we   (reg_we),
        .wr_idx   (wr_idx),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .stk_push (stk_push),
        .stk_pop  (stk_pop),
        .br_cond  (br_cond),
        .jmp      (jmp),
        .call     (call),
        .ret      (ret),
        .sys      (sys),
        .illegal  (illegal)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic bit is_defined(input logic [5:0] op);
        case (op)
            6'o00, 6'o01, 6'o02, 6'o03, 6'o04, 6'o10, 6'o11,
            6'o20, 6'o21, 6'o22, 6'o23, 6'o24, 6'o25, 6'o26,
            6'o30, 6'o31, 6'o32, 6'o33, 6'o34,
            6'o40, 6'o41, 6'o42, 6'o43, 6'o70: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit writes_reg(input logic [5:0] op);
        case (op)
            6'o00, 6'o01, 6'o02, 6'o03, 6'o04, 6'o10, 6'o11,
            6'o21, 6'o22, 6'o23, 6'o24, 6'o25, 6'o26,
            6'o30, 6'o31, 6'o34: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Drive one word and compare every output with the model.
    task automatic apply_and_check(input logic [31:0] w);
        logic [5:0]  op;
        logic [31:0] exp_imm;
        logic [4:0]  exp_wr;
        @(negedge clk);
        insn = w;
        #5;
        op      = w[31:26];
        exp_imm = {{16{w[15]}}, w[15:0]};
        if (!writes_reg(op))    exp_wr = 5'd0;
        else if (op == 6'o31)   exp_wr = w[20:16];
        else                    exp_wr = w[25:21];
        check("R1", "ra_idx", 32'(ra_idx), 32'(w[25:21]));
        check("R1", "rb_idx", 32'(rb_idx), 32'(w[20:16]));
        check("R1", "rc_idx", 32'(rc_idx), 32'(w[15:11]));
        check("R2", "imm", imm, exp_imm);
        check("R3", "opcode", 32'(opcode), 32'(op));
        check("R3", "group", 32'(group), 32'(op[5:3]));
        check("R4", "illegal", 32'(illegal), 32'(!is_defined(op)));
        check("R5", "reg_we", 32'(reg_we), 32'(writes_reg(op)));
        check("R6", "wr_idx", 32'(wr_idx), 32'(exp_wr));
        check("R7", "mem_rd", 32'(mem_rd), 32'(op == 6'o31 || op == 6'o34 || op == 6'o43));
        check("R7", "mem_wr", 32'(mem_wr), 32'(op == 6'o32 || op == 6'o33 || op == 6'o42));
        check("R8", "stk_push", 32'(stk_push), 32'(op == 6'o33 || op == 6'o42));
        check("R8", "stk_pop", 32'(stk_pop), 32'(op == 6'o34 || op == 6'o43));
        check("R9", "br_cond", 32'(br_cond), 32'(op == 6'o40));
        check("R9", "jmp", 32'(jmp), 32'(op == 6'o41));
        check("R9", "call", 32'(call), 32'(op == 6'o42));
        check("R9", "ret", 32'(ret), 32'(op == 6'o43));
        check("R10", "sys", 32'(sys), 32'(op == 6'o70));
        if (illegal)   // R11: an undefined opcode leaves every strobe low
            check("R11", "strobes", 32'({reg_we, mem_rd, mem_wr, stk_push, stk_pop,
                                         br_cond, jmp, call, ret, sys}), 32'd0);
        // R12: never more than one control-flow strobe
        check("R12", "flow count", 32'($countones({br_cond, jmp, call, ret})),
              32'(op inside {6'o40, 6'o41, 6'o42, 6'o43}));
    endtask

    // Word zero decodes as add r0, r0, r0 while reset is held.
    task automatic t_reset_state();
        rst_n = 1'b0;
        apply_and_check(32'h0000_0000);
        check("R5", "reset word writes", 32'(reg_we), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Every opcode value with several field patterns.
    task automatic t_all_opcodes();
        for (int op = 0; op < 64; op++) begin
            for (int k = 0; k < 4; k++) begin
                logic [25:0] body;
                body = 26'($urandom);
                apply_and_check({6'(op), body});
            end
            apply_and_check({6'(op), 26'h3FF_FFFF});
            apply_and_check({6'(op), 26'h000_0000});
        end
    endtask

    // Walking patterns that separate the register fields (R1).
    task automatic t_field_walk();
        for (int i = 0; i < 26; i++) begin
            apply_and_check({6'o31, 26'(1) << i});
            apply_and_check({6'o00, ~(26'(1) << i)});
        end
        apply_and_check({6'o31, 5'd3, 5'd17, 16'h0000});   // R6: load writes b
        check("R6", "load dest", 32'(wr_idx), 32'd17);
        apply_and_check({6'o30, 5'd9, 5'd30, 16'h0005});   // R6: move writes a
        check("R6", "move dest", 32'(wr_idx), 32'd9);
    endtask

    // Immediate boundary values around the sign bit (R2).
    task automatic t_imm_edges();
        apply_and_check({6'o30, 5'd1, 5'd0, 16'h7FFF});
        check("R2", "imm max positive", imm, 32'h0000_7FFF);
        apply_and_check({6'o30, 5'd1, 5'd0, 16'h8000});
        check("R2", "imm min negative", imm, 32'hFFFF_8000);
        apply_and_check({6'o41, 5'd0, 5'd0, 16'hFFFF});
        check("R2", "imm minus one", imm, 32'hFFFF_FFFF);
        apply_and_check({6'o40, 5'd2, 5'd0, 16'h0000});
        check("R2", "imm zero", imm, 32'h0000_0000);
    endtask

    // Undefined neighbours of defined codes stay silent (R4, R11).
    task automatic t_illegal_edges();
        apply_and_check({6'o05, 26'h3FF_FFFF});
        check("R4", "op 05 illegal", 32'(illegal), 32'd1);
        apply_and_check({6'o27, 26'h155_5555});
        check("R11", "op 27 no write", 32'(reg_we), 32'd0);
        apply_and_check({6'o44, 26'h2AA_AAAA});
        check("R4", "op 44 illegal", 32'(illegal), 32'd1);
        apply_and_check({6'o77, 26'h3FF_FFFF});
        check("R11", "op 77 no sys", 32'(sys), 32'd0);
    endtask

    initial begin
        t_reset_state();
        t_all_opcodes();
        t_field_walk();
        t_imm_edges();
        t_illegal_edges();
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule